// File: doc/BRIEF.md
# Clear-on-Read Sensor Interrupt Controller

This block merges the interrupt events of a multi-stage capacitive sensing sequencer into one active-low request line for a host. It handles four event sources:

- conversion-stage completion pulses, one per stage;
- low-limit threshold levels, one per stage;
- high-limit threshold levels, one per stage;
- a single general-purpose event pulse.

Each source has an enable register and a status register. The host reaches them through a small register port with an address strobe.

Completion and general-purpose events set sticky status bits. For the two threshold sources, any change of a stage's level sets a pending bit. A rising level (touch) and a falling level (lift-off) therefore both raise an interrupt. A change in the set of touched stages also raises one. Reading a threshold status register returns the present levels, not the pending bits.

Reading a status address clears the pending bits of that source at once, in the same clock edge that captures the read data. A bit whose event is present in that same cycle stays set. In typical use only the last stage of the sequence has its completion enable set, so the line falls once per full pass of the sequencer. The request line idles high and only ever goes low, so it can drive an open-drain pad.

Top module: `sense_irq_ctrl`

## Requirements
- R1: After reset, `irq_n_o` is 1, every enable register reads 0 and `bus_rdata_o` is 0.
- R2: Register map by `bus_addr_i`:
  - 0x0: completion enable.
  - 0x1: low-threshold enable.
  - 0x2: high-threshold enable.
  - 0x3: general-purpose enable, bit 0 only.
  - 0x4 to 0x7: the status registers, in the same source order.
  - Enables read back the written value masked to `N_STAGES` bits (1 bit for 0x3).
  - Bits at or above `N_STAGES`, and every unmapped address, read 0.
- R3: A completion pulse on stage k with enable bit k set drives `irq_n_o` low at the clock edge that samples the pulse.
- R4: An event on a stage whose enable bit is 0 records its status bit but leaves `irq_n_o` high.
- R5: A read is a cycle with `bus_stb_i`=1 and `bus_we_i`=0. The data appears on `bus_rdata_o` after that edge. A read of a status address clears that source's pending bits at the same edge. `irq_n_o` returns high at that edge when nothing enabled remains pending.
- R6: An event arriving in the same cycle as a clearing read of its source keeps its bit set, and the line stays low.
- R7: On an enabled stage, any change of a threshold level (0 to 1 or 1 to 0) drives `irq_n_o` low at the sampling edge. The line stays low until that source's status address is read.
- R8: Reading address 0x5 or 0x6 returns the threshold levels present in the read cycle, bit k for stage k.
- R9: A general-purpose event with enable bit 0 set drives `irq_n_o` low. Reading address 0x7 returns 1 in bit 0 and clears the event.
- R10: Writes to status addresses 0x4 to 0x7 change no state.
- R11: A status read clears only its own source. `irq_n_o` stays low while another enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cc_done_i | input | N_STAGES | Per-stage conversion-complete pulses |
| thr_lo_i | input | N_STAGES | Per-stage low-limit threshold levels |
| thr_hi_i | input | N_STAGES | Per-stage high-limit threshold levels |
| gpio_evt_i | input | 1 | General-purpose event pulse |
| bus_stb_i | input | 1 | Address strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid after the strobe edge |
| irq_n_o | output | 1 | Interrupt request, active low, 1 = released |

## Verification
The bench builds the block with `N_STAGES`=12 and `DATA_W`=16. This leaves four data bits above the last stage, so the masking of enables and the zero upper read bits can be observed at the port. Twelve stages allow the bench to enable only the highest stage and to trigger a disabled low stage. They also allow it to step the threshold levels through touch, a second touched stage and full release. The bench checks each status readback through a scoreboard queue of expected read data. It checks the request line at fixed points after each event and read, including a read that collides with a new event.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_SRC = 4;  // completion, low thr, high thr, gpio
  localparam int unsigned EN_BASE = 0;
  localparam int unsigned ST_BASE = 4;
  localparam int unsigned SRC_LO  = 1;
  localparam int unsigned SRC_HI  = 2;
  localparam int unsigned SRC_GP  = 3;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/sirq_pend_bank.sv
module sirq_pend_bank #(
  parameter int unsigned WIDTH      = 12,
  parameter bit          CHANGE_DET = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] src_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] pend_o,
  output logic [WIDTH-1:0] pend_nxt_o
);
  logic [WIDTH-1:0] evt;

  generate
    if (CHANGE_DET) begin : g_change
      logic [WIDTH-1:0] prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= src_i;
      end
      assign evt = src_i ^ prev_q;
    end else begin : g_pulse
      assign evt = src_i;
    end
  endgenerate

  // a fresh event survives a same-cycle clear
  assign pend_nxt_o = (pend_o & ~{WIDTH{clr_i}}) | evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= pend_nxt_o;
  end

  AST_EVT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt) |=> ((pend_o & $past(evt)) == $past(evt))); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && evt == '0) |=> (pend_o == '0)); // R5
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int unsigned N_STAGES = 12,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              stb_i,
  input  logic                              we_i,
  input  addr_t                             addr_i,
  input  logic [DATA_W-1:0]                 wdata_i,
  input  logic [NUM_SRC-1:0][N_STAGES-1:0]  src_i,
  input  logic [NUM_SRC-1:0][N_STAGES-1:0]  pend_i,
  output logic [NUM_SRC-1:0][N_STAGES-1:0]  en_o,
  output logic [NUM_SRC-1:0][N_STAGES-1:0]  en_nxt_o,
  output logic [NUM_SRC-1:0]                clr_o,
  output logic [DATA_W-1:0]                 rdata_o
);
  logic [NUM_SRC-1:0][N_STAGES-1:0] stat_view;
  logic [DATA_W-1:0] rd_val;
  logic unused_hi;
  assign unused_hi = ^wdata_i[DATA_W-1:N_STAGES];

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam logic [N_STAGES-1:0] MASK =
        (i == SRC_GP) ? {{(N_STAGES-1){1'b0}}, 1'b1} : {N_STAGES{1'b1}};
      logic wr_hit;
      assign wr_hit      = stb_i && we_i && (addr_i == ADDR_W'(EN_BASE + i));
      assign clr_o[i]    = stb_i && !we_i && (addr_i == ADDR_W'(ST_BASE + i));
      assign en_nxt_o[i] = wr_hit ? (wdata_i[N_STAGES-1:0] & MASK) : en_o[i];
      // threshold status reads show live levels; others show sticky bits
      if (i == SRC_LO || i == SRC_HI) begin : g_lvl
        assign stat_view[i] = src_i[i];
      end else begin : g_stk
        assign stat_view[i] = pend_i[i];
      end
    end
  endgenerate

  always_comb begin
    rd_val = '0;
    for (int unsigned k = 0; k < NUM_SRC; k++) begin
      if (addr_i == ADDR_W'(EN_BASE + k)) rd_val[N_STAGES-1:0] = en_o[k];
      if (addr_i == ADDR_W'(ST_BASE + k)) rd_val[N_STAGES-1:0] = stat_view[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      rdata_o <= '0;
    end else begin
      en_o <= en_nxt_o;
      if (stb_i && !we_i) rdata_o <= rd_val;
    end
  end

  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DATA_W-1:N_STAGES] == '0); // R2
  AST_ST_WRITE_KEEPS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && we_i && addr_i >= ADDR_W'(ST_BASE)) |=> $stable(en_o)); // R10
endmodule

// File: rtl/sense_irq_ctrl.sv
module sense_irq_ctrl
  import sirq_pkg::*;
#(
  parameter int unsigned N_STAGES = 12,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_STAGES-1:0] cc_done_i,
  input  logic [N_STAGES-1:0] thr_lo_i,
  input  logic [N_STAGES-1:0] thr_hi_i,
  input  logic                gpio_evt_i,
  input  logic                bus_stb_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  output logic                irq_n_o
);
  logic [NUM_SRC-1:0][N_STAGES-1:0] src, pend, pend_nxt, en, en_nxt;
  logic [NUM_SRC-1:0]               clr;
  logic                             irq_q;

  assign src[0]      = cc_done_i;
  assign src[SRC_LO] = thr_lo_i;
  assign src[SRC_HI] = thr_hi_i;
  assign src[SRC_GP] = {{(N_STAGES-1){1'b0}}, gpio_evt_i};

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bank
      sirq_pend_bank #(
        .WIDTH     (N_STAGES),
        .CHANGE_DET((i == SRC_LO) || (i == SRC_HI))
      ) u_bank (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src[i]),
        .clr_i     (clr[i]),
        .pend_o    (pend[i]),
        .pend_nxt_o(pend_nxt[i])
      );
    end
  endgenerate

  sirq_regs #(
    .N_STAGES(N_STAGES),
    .DATA_W  (DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (bus_stb_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .src_i   (src),
    .pend_i  (pend),
    .en_o    (en),
    .en_nxt_o(en_nxt),
    .clr_o   (clr),
    .rdata_o (bus_rdata_o)
  );

  // registered line: released in the same edge that applies a clearing read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= ~|(pend_nxt & en_nxt);
  end
  assign irq_n_o = irq_q;

  AST_LINE_TRACKS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_n_o == ~|(pend & en)); // R4
  AST_DONE_PULLS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((cc_done_i & en[0]) != '0) && !(bus_stb_i && bus_we_i)) |=> !irq_n_o); // R3
  AST_THR_CHANGE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((((thr_lo_i ^ $past(thr_lo_i)) & en[SRC_LO]) != '0) && !bus_stb_i) |=> !irq_n_o); // R7
endmodule

// File: tb/sense_irq_ctrl_tb.sv
module sense_irq_ctrl_tb;
  localparam int unsigned N  = 12;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] cc_done = '0, thr_lo = '0, thr_hi = '0;
  logic gpio_evt = 1'b0;
  logic stb = 1'b0, we = 1'b0;
  logic [3:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  sense_irq_ctrl #(.N_STAGES(N), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cc_done_i(cc_done), .thr_lo_i(thr_lo),
    .thr_hi_i(thr_hi), .gpio_evt_i(gpio_evt), .bus_stb_i(stb), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_n_o(irq_n)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check_irq(input logic exp, input string tag);
    checks++;
    if (irq_n !== exp) begin
      errors++;
      $display("FAIL %s irq_n actual=%0b expected=%0b", tag, irq_n, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [DW-1:0] d);
    stb = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    stb = 1'b0; we = 1'b0;
  endtask

  // driver: queue expected data, then strobe one read cycle
  task automatic bus_read(input logic [3:0] a, input logic [DW-1:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    stb = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic pulse_cc(input logic [N-1:0] v);
    cc_done = v;
    @(negedge clk);
    cc_done = '0;
  endtask

  // monitor: every read strobe produces data after the edge
  initial begin
    forever begin
      @(posedge clk);
      if (stb && !we) begin
        @(negedge clk);
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard empty actual=%0h expected=none", rdata);
        end else begin
          logic [DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (rdata !== e) begin
            errors++;
            $display("FAIL %s rdata actual=%0h expected=%0h", t, rdata, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_irq(1'b1, "R1 reset line");
    checks++;
    if (rdata !== '0) begin
      errors++;
      $display("FAIL R1 reset rdata actual=%0h expected=0", rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(4'h0, 16'h0000, "R1 completion enable after reset");
    bus_read(4'h1, 16'h0000, "R1 low enable after reset");

    // R2 enables and masking
    bus_write(4'h0, 16'hFFFF);
    bus_read(4'h0, 16'h0FFF, "R2 completion enable masked");
    bus_write(4'h0, 16'h0800);
    bus_write(4'h1, 16'hFFFF);
    bus_write(4'h2, 16'h0001);
    bus_write(4'h3, 16'hFFFF);
    bus_read(4'h1, 16'h0FFF, "R2 low enable");
    bus_read(4'h2, 16'h0001, "R2 high enable");
    bus_read(4'h3, 16'h0001, "R2 gpio enable one bit");
    bus_read(4'h9, 16'h0000, "R2 unmapped address");

    // R4 disabled stage
    pulse_cc(12'h008);
    check_irq(1'b1, "R4 disabled stage keeps line high");
    bus_read(4'h4, 16'h0008, "R4 disabled stage status recorded");

    // R3 / R5 last stage
    pulse_cc(12'h800);
    check_irq(1'b0, "R3 last stage pulls line low");
    bus_read(4'h4, 16'h0800, "R3 status bit of last stage");
    check_irq(1'b1, "R5 line released by status read");
    bus_read(4'h4, 16'h0000, "R5 status cleared by read");

    // R6 event collides with read
    pulse_cc(12'h800);
    exp_q.push_back(16'h0800);
    tag_q.push_back("R6 collision read data");
    cc_done = 12'h800; stb = 1'b1; we = 1'b0; addr = 4'h4;
    @(negedge clk);
    cc_done = '0; stb = 1'b0;
    check_irq(1'b0, "R6 line held by same-cycle event");
    bus_read(4'h4, 16'h0800, "R6 bit survived clearing read");
    check_irq(1'b1, "R6 line released afterwards");

    // R7 / R8 touch, more touched, lift-off
    thr_lo = 12'h004;
    @(negedge clk);
    check_irq(1'b0, "R7 touch pulls line low");
    @(negedge clk);
    check_irq(1'b0, "R7 line stays low until read");
    bus_read(4'h5, 16'h0004, "R8 low status shows live levels");
    check_irq(1'b1, "R7 released by low status read");
    thr_lo = 12'h006;
    @(negedge clk);
    check_irq(1'b0, "R7 touched count change");
    bus_read(4'h5, 16'h0006, "R8 two stages touched");
    thr_lo = 12'h000;
    @(negedge clk);
    check_irq(1'b0, "R7 lift-off pulls line low");
    bus_read(4'h5, 16'h0000, "R8 released levels");
    check_irq(1'b1, "R7 released after lift-off read");

    // high threshold on a disabled stage
    thr_hi = 12'h020;
    @(negedge clk);
    check_irq(1'b1, "R4 disabled high threshold stage");
    bus_read(4'h6, 16'h0020, "R8 high status live level");
    thr_hi = 12'h000;
    @(negedge clk);
    bus_read(4'h6, 16'h0000, "R8 high level gone");

    // R11 / R9 two sources pending
    gpio_evt = 1'b1;
    cc_done = 12'h800;
    @(negedge clk);
    gpio_evt = 1'b0;
    cc_done = '0;
    check_irq(1'b0, "R9 gpio and completion pending");
    bus_read(4'h4, 16'h0800, "R11 completion read");
    check_irq(1'b0, "R11 line held by pending gpio");
    bus_read(4'h7, 16'h0001, "R9 gpio status");
    check_irq(1'b1, "R9 released by gpio read");

    // R10 status writes ignored
    bus_write(4'h4, 16'hFFFF);
    bus_write(4'h7, 16'hFFFF);
    check_irq(1'b1, "R10 status write leaves line high");
    bus_read(4'h4, 16'h0000, "R10 completion status unchanged");
    bus_read(4'h7, 16'h0000, "R10 gpio status unchanged");
    bus_read(4'h0, 16'h0800, "R10 enable unchanged");

    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule